// File: doc/BRIEF.md
# Shared-Resource Priority Arbiter with Bounded Wait

This block decides, every clock cycle, which of several requesters may use one shared local resource, such as a tightly coupled memory bank. Each requester's urgency comes from one of two places. It can come from a priority value carried with the transfer itself. It can also come from a programmed priority held in that requester's configuration slot. Either way, the scale runs from 0 (most urgent) to 8 (least urgent). The decision is combinational from the current requests and the block's state, so a grant applies in the same cycle as the request it answers.

Strict priority alone could shut a low-urgency requester out indefinitely. To prevent this, a single wait counter per resource measures how many cycles in a row some eligible requester has been passed over. Every configuration slot holds a wait bound. When the counter reaches the bound of the requester currently picked as most starved, that requester wins the cycle outright, and the counter starts again from zero. One requester index is wired as permanently most urgent, and it beats even a forced grant. A parameter mask decides which requesters may ever be forced through. Configuration is written one slot at a time through a simple write strobe.

Top module: `res_arb`

## Requirements
- R1: Out of reset no grant is asserted while no request is active, the wait counter is 0, every wait bound is 0 and every programmed priority is 8.
- R2: Effective priority 0 is most urgent and 8 least urgent; values 9 to 15 (from either source) are treated as 8; the lowest effective value wins.
- R3: Among requesters with equal effective priority, the lowest index wins.
- R4: Requesters whose bit is set in HAS_PRI (default requesters 1 and 3) use their programmed priority, and the others use their `req_pri` nibble (bits 4i+3..4i); a slot write takes effect from the cycle after `cfg_we`.
- R5: Requester TOP_IDX (default 0) is granted whenever it requests, whatever any priority value or counter state.
- R6: At most one grant is asserted per cycle, only for an active request, and some grant is asserted whenever any request is active.
- R7: The wait counter is cleared when no eligible requester is being held off, and otherwise rises by one per cycle, saturating at its maximum.
- R8: The starved candidate is the held-off eligible requester with the largest effective priority value, ties to the lowest index. When its wait bound is nonzero and the counter is at or above it, the candidate is granted that cycle, and the counter returns to 0.
- R9: A wait bound of 0 disables the forced grant for that candidate.
- R10: A requester whose BOOST_MASK bit is clear (default requester 2) is never force-granted and never counts as waiting.
- R11: While TOP_IDX requests, a due forced grant is deferred and the counter keeps rising. The forced grant fires in the first cycle TOP_IDX is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | NREQ | Per-requester request |
| req_pri | input | NREQ*4 | Per-transfer priority, nibble i for requester i |
| cfg_we | input | 1 | Configuration slot write strobe |
| cfg_idx | input | IDX_W | Slot index to write |
| cfg_pri | input | 4 | Programmed priority to store |
| cfg_maxwait | input | MW_W | Wait bound to store |
| gnt | output | NREQ | One-hot grant, combinational |

## Verification
The bench uses the defaults: four requesters, requester 0 fixed on top, programmed priority for requesters 1 and 3, and requester 2 excluded from forcing. This mix exercises both priority sources, the fixed top requester and an ineligible requester in one build. The counter width is 8 bits, but the bench writes wait bounds of 0 to 5 only. Forced grants therefore come up often in random traffic, and the deferral behind requester 0 and the switch of candidate between bounds are reached within a few cycles.

// File: rtl/res_arb_pkg.sv
package res_arb_pkg;
  localparam int PRI_W      = 4;
  localparam int PRI_LOWEST = 8;

  typedef logic [PRI_W-1:0] pri_t;

  // Values outside the 0..8 scale are treated as the least urgent level
  function automatic pri_t pri_clamp(input pri_t p);
    return (p > pri_t'(PRI_LOWEST)) ? pri_t'(PRI_LOWEST) : p;
  endfunction
endpackage

// File: rtl/res_arb_cfg.sv
module res_arb_cfg
  import res_arb_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int MW_W  = 8,
  parameter int IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  pri_t                      wr_pri,
  input  logic [MW_W-1:0]           wr_mw,
  output pri_t [NREQ-1:0]           pri_o,
  output logic [NREQ-1:0][MW_W-1:0] mw_o
);
  pri_t [NREQ-1:0]           pri_q, pri_d;
  logic [NREQ-1:0][MW_W-1:0] mw_q,  mw_d;
  logic [NREQ-1:0]           slot_en;

  // Per-slot clock enable decoded from the write strobe
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      slot_en[i] = wr_en && (int'(wr_idx) == i);
      pri_d[i]   = wr_pri;
      mw_d[i]    = wr_mw;
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pri_q[g] <= pri_t'(PRI_LOWEST);
        mw_q[g]  <= '0;
      end else if (slot_en[g]) begin
        pri_q[g] <= pri_d[g];
        mw_q[g]  <= mw_d[g];
      end
    end
  end

  assign pri_o = pri_q;
  assign mw_o  = mw_q;
endmodule

// File: rtl/res_arb_pick.sv
module res_arb_pick
  import res_arb_pkg::*;
#(
  parameter int NREQ     = 4,
  parameter bit PICK_LOW = 1'b0,   // 0: most urgent value, 1: least urgent value
  parameter int IDX_W    = 2
) (
  input  logic [NREQ-1:0] vld,
  input  pri_t [NREQ-1:0] pri,
  output logic            found,
  output logic [IDX_W-1:0] idx
);
  pri_t best;

  // Strict comparisons keep the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (vld[i]) begin
        if (!found || (PICK_LOW ? (pri[i] > best) : (pri[i] < best))) begin
          found = 1'b1;
          idx   = IDX_W'(i);
          best  = pri[i];
        end
      end
    end
  end
endmodule

// File: rtl/res_arb_wait_ctr.sv
module res_arb_wait_ctr #(
  parameter int MW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            waiting,
  input  logic            forced,
  output logic [MW_W-1:0] cnt_q
);
  logic [MW_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!waiting || forced) begin
      cnt_d = '0;
    end else if (cnt_q == '1) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/res_arb.sv
module res_arb
  import res_arb_pkg::*;
#(
  parameter int              NREQ       = 4,
  parameter int              MW_W       = 8,
  parameter int              TOP_IDX    = 0,
  parameter logic [NREQ-1:0] HAS_PRI    = 4'b1010,
  parameter logic [NREQ-1:0] BOOST_MASK = 4'b1011,
  localparam int             IDX_W      = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         req,
  input  logic [NREQ*PRI_W-1:0]   req_pri,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [PRI_W-1:0]        cfg_pri,
  input  logic [MW_W-1:0]         cfg_maxwait,
  output logic [NREQ-1:0]         gnt
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pri_t [NREQ-1:0]           prog_pri;
  logic [NREQ-1:0][MW_W-1:0] prog_mw;

  res_arb_cfg #(.NREQ(NREQ), .MW_W(MW_W), .IDX_W(IDX_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_we),
    .wr_idx(cfg_idx),
    .wr_pri(cfg_pri),
    .wr_mw (cfg_maxwait),
    .pri_o (prog_pri),
    .mw_o  (prog_mw)
  );

  // Effective priority: programmed slot or per-transfer value
  pri_t [NREQ-1:0] eff_pri;
  for (genvar g = 0; g < NREQ; g++) begin : g_eff
    assign eff_pri[g] = HAS_PRI[g] ? pri_clamp(prog_pri[g])
                                   : pri_clamp(req_pri[g*PRI_W +: PRI_W]);
  end

  logic             norm_v;
  logic [IDX_W-1:0] norm_idx;

  res_arb_pick #(.NREQ(NREQ), .PICK_LOW(1'b0), .IDX_W(IDX_W)) u_pick_win (
    .vld  (req),
    .pri  (eff_pri),
    .found(norm_v),
    .idx  (norm_idx)
  );

  logic             top_req;
  logic [IDX_W-1:0] win_idx;
  logic [NREQ-1:0]  win_oh;
  logic [NREQ-1:0]  wait_mask;

  assign top_req   = req[TOP_IDX];
  assign win_idx   = top_req ? IDX_W'(TOP_IDX) : norm_idx;
  assign win_oh    = norm_v ? (NREQ'(1) << win_idx) : '0;
  assign wait_mask = req & BOOST_MASK & ~win_oh;

  logic             cand_v;
  logic [IDX_W-1:0] cand_idx;

  res_arb_pick #(.NREQ(NREQ), .PICK_LOW(1'b1), .IDX_W(IDX_W)) u_pick_starved (
    .vld  (wait_mask),
    .pri  (eff_pri),
    .found(cand_v),
    .idx  (cand_idx)
  );

  logic [MW_W-1:0] mw_sel;
  logic [MW_W-1:0] cnt_q;
  logic            fire;

  assign mw_sel = prog_mw[cand_idx];
  assign fire   = cand_v && (mw_sel != '0) && (cnt_q >= mw_sel) && !top_req;

  res_arb_wait_ctr #(.MW_W(MW_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .waiting(cand_v),
    .forced (fire),
    .cnt_q  (cnt_q)
  );

  assign gnt = fire ? (NREQ'(1) << cand_idx) : win_oh;
endmodule

// File: rtl/res_arb_chk.sv
module res_arb_chk #(
  parameter int NREQ    = 4,
  parameter int MW_W    = 8,
  parameter int TOP_IDX = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req,
  input logic [NREQ-1:0] gnt,
  input logic [MW_W-1:0] cnt_q,
  input logic            fire,
  input logic            cand_v,
  input logic [MW_W-1:0] mw_sel
);
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  p_work_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  p_top_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req[TOP_IDX] |-> gnt[TOP_IDX]);

  p_clear_after_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));

  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_v |=> (cnt_q == '0));

  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_v && !fire && (cnt_q != '1)) |=> (cnt_q == MW_W'($past(cnt_q) + 1'b1)));

  p_zero_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sel == '0) |-> !fire);

  p_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req[TOP_IDX] |-> !fire);
endmodule

bind res_arb res_arb_chk #(.NREQ(NREQ), .MW_W(MW_W), .TOP_IDX(TOP_IDX)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .req   (req),
  .gnt   (gnt),
  .cnt_q (cnt_q),
  .fire  (fire),
  .cand_v(cand_v),
  .mw_sel(mw_sel)
);

// File: tb/res_arb_tb.sv
`timescale 1ns/1ps
module res_arb_tb;
  localparam logic [3:0] HAS_PRI    = 4'b1010;
  localparam logic [3:0] BOOST_MASK = 4'b1011;

  logic        clk;
  logic        rst_n;
  logic [3:0]  req;
  logic [15:0] req_pri;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [3:0]  cfg_pri;
  logic [7:0]  cfg_maxwait;
  logic [3:0]  gnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench model state
  int m_pri [4];
  int m_mw  [4];
  int m_cnt;

  res_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_pri(req_pri),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pri(cfg_pri),
    .cfg_maxwait(cfg_maxwait), .gnt(gnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int clampv(input int p);
    return (p > 8) ? 8 : p;
  endfunction

  function automatic int eff(input int i, input logic [15:0] p);
    return HAS_PRI[i] ? clampv(m_pri[i]) : clampv(int'(p[i*4 +: 4]));
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] r, input logic [15:0] p,
                      input logic we, input logic [1:0] wi, input logic [3:0] wp,
                      input logic [7:0] wm);
    int w, c, bw, bc, nxt;
    bit fire;
    logic [3:0] exp;
    @(negedge clk);
    req = r; req_pri = p; cfg_we = we; cfg_idx = wi; cfg_pri = wp; cfg_maxwait = wm;
    #1;
    w = -1; bw = 0;
    if (r[0]) w = 0;
    else for (int i = 0; i < 4; i++)
      if (r[i] && (w < 0 || eff(i, p) < bw)) begin w = i; bw = eff(i, p); end
    c = -1; bc = 0;
    for (int i = 0; i < 4; i++)
      if (r[i] && BOOST_MASK[i] && i != w && (c < 0 || eff(i, p) > bc)) begin
        c = i; bc = eff(i, p);
      end
    fire = (c >= 0) && (m_mw[c] != 0) && (m_cnt >= m_mw[c]) && !r[0];
    exp = fire ? 4'(1 << c) : (w >= 0 ? 4'(1 << w) : 4'b0);
    check(tag, gnt, exp);
    n_tests++;
    if (!$onehot0(gnt) || ((gnt & ~r) != 4'b0) || ((r != 4'b0) && (gnt == 4'b0))) begin
      n_fail++;
      $display("FAIL R6: gnt=%b req=%b expected single grant to a requester", gnt, r);
    end
    nxt = (c < 0 || fire) ? 0 : ((m_cnt == 255) ? 255 : m_cnt + 1);
    @(posedge clk);
    m_cnt = nxt;
    if (we) begin m_pri[wi] = int'(wp); m_mw[wi] = int'(wm); end
  endtask

  task automatic idle(input string tag, input logic [3:0] r, input logic [15:0] p, input int n);
    for (int k = 0; k < n; k++) step(tag, r, p, 1'b0, 2'd0, 4'd0, 8'd0);
  endtask

  task automatic wr(input string tag, input logic [1:0] i, input logic [3:0] pr, input logic [7:0] mw);
    step(tag, 4'b0000, 16'h0, 1'b1, i, pr, mw);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_pri[i] = 8; m_mw[i] = 0; end
    m_cnt = 0;
    rst_n = 1'b0; req = '0; req_pri = '0; cfg_we = 1'b0; cfg_idx = '0;
    cfg_pri = '0; cfg_maxwait = '0;
    repeat (3) @(negedge clk);
    #1; check("R1 during reset", gnt, 4'b0000);
    rst_n = 1'b1;
    idle("R1", 4'b0000, 16'h0, 4);

    // R2: requester 2 carries 9 (treated as 8), requester 3 programmed 8: tie -> 2
    idle("R2", 4'b1100, 16'h0900, 2);
    // R2: requester 2 at 3 beats requester 3 at 8
    idle("R2", 4'b1100, 16'h0300, 2);
    // R3: programme 1 and 3 both to 5 -> requester 1
    wr("R3", 2'd1, 4'd5, 8'd0);
    wr("R3", 2'd3, 4'd5, 8'd0);
    idle("R3", 4'b1010, 16'h0000, 2);
    // R4: requester 3 programmed 1, its nibble 15 ignored, beats requester 2 at 2
    step("R4", 4'b1100, 16'hF200, 1'b1, 2'd3, 4'd1, 8'd0);
    idle("R4", 4'b1100, 16'hF200, 2);
    // R5: requester 0 at 15 still wins
    idle("R5", 4'b1111, 16'h000F, 3);
    // R9: bounds all zero, long contention, never forced
    wr("R9", 2'd3, 4'd8, 8'd0);
    idle("R9", 4'b1110, 16'h0000, 20);
    // R7/R8: bound 3 on requester 3 while requester 2 (pri 0) wins
    wr("R8", 2'd3, 4'd8, 8'd3);
    idle("R7", 4'b1100, 16'h0000, 3);
    idle("R8", 4'b1100, 16'h0000, 6);
    idle("R7", 4'b0000, 16'h0000, 2);
    // R10: requester 2 is ineligible even with a bound
    wr("R10", 2'd2, 4'd0, 8'd1);
    wr("R10", 2'd1, 4'd0, 8'd0);
    idle("R10", 4'b0110, 16'h0800, 10);
    // R11: forced grant due behind requester 0, fires once 0 drops
    wr("R11", 2'd3, 4'd8, 8'd2);
    idle("R11", 4'b1011, 16'h0000, 5);
    idle("R11", 4'b1010, 16'h0000, 3);

    // Random traffic with occasional slot writes
    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  r;
      logic [15:0] p;
      logic        we;
      r  = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) r[0] = 1'b0;
      p  = 16'($urandom);
      we = ($urandom_range(0, 9) == 0);
      step("R8 random", r, p, we, 2'($urandom_range(0, 3)),
           4'($urandom_range(0, 15)), 8'($urandom_range(0, 5)));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule